// File: doc/BRIEF.md
# Single-Adder Arithmetic-Logic Unit

This block is a purely combinational 8-bit ALU in which every operation, logical ones included, comes out of one shared ripple adder. A row of identical per-bit conditioning cells rewrites the two operands before they reach the adder. A separate cell derives the adder's carry-in from the opcode alone. With the right pair of rewritten operands and the right carry-in, the wanted result appears directly at the adder's sum. No result multiplexer and no parallel bank of function units are used.

A 3-bit opcode selects the operation. The sum is the result, and the adder's carry-out is exposed as a status bit that carries meaning only for the arithmetic opcodes. The block holds no state. The clock and reset on its port list serve only to sample its embedded checks.

Top module: `adder_alu`

## Requirements
- R1: Opcode 3'b000 gives res = a + b (mod 256), and cout is the carry out of bit 7.
- R2: Opcode 3'b001 gives res = a - b (mod 256), computed as a + ~b + 1, and cout = 1 exactly when a >= b (unsigned).
- R3: Opcode 3'b010 gives res = a + 1 (mod 256), and cout = 1 exactly when a == 8'hFF.
- R4: Opcode 3'b011 gives res = a, and cout = 0.
- R5: Opcode 3'b100 gives res = a & b, and cout = 0.
- R6: Opcode 3'b101 gives res = a | b, and cout = 0.
- R7: Opcode 3'b110 gives res = a ^ b, and cout = 0.
- R8: Opcode 3'b111 gives res = ~a, and cout = 0.
- R9: The result depends only on the current inputs. No value is retained between evaluations, so the same inputs always give the same output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock used only by the embedded assertions |
| rst_n | input | 1 | Active-low reset that disables the embedded assertions |
| a | input | 8 | First operand |
| b | input | 8 | Second operand |
| op | input | 3 | Operation select |
| res | output | 8 | Adder sum, which is the operation result |
| cout | output | 1 | Adder carry-out, meaningful for opcodes 000 to 010 |

## Verification
The assertions sample `res` and `cout` at the rising clock edge. They therefore assume the operands and opcode are stable around that edge and free of X or Z. The bench changes its inputs only on the falling edge and always drives fully known values, so each edge sees settled combinational outputs. Operands cover random values and the corner values 0x00, 0xFF and 0x80, each paired with every opcode.

// File: rtl/adder_alu.sv
module adder_alu #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [2:0]   op,
  output logic [W-1:0] res,
  output logic         cout
);

  logic [W-1:0] ia, ib;
  logic         cin;
  logic [W:0]   carry;

  // per-bit conditioning cells
  for (genvar i = 0; i < W; i++) begin : g_cell
    always_comb begin
      ib[i] = 1'b0;
      unique case (op)
        3'b000: begin ia[i] = a[i];          ib[i] = b[i];  end
        3'b001: begin ia[i] = a[i];          ib[i] = ~b[i]; end
        3'b010,
        3'b011: ia[i] = a[i];
        3'b100: ia[i] = a[i] & b[i];
        3'b101: ia[i] = a[i] | b[i];
        3'b110: ia[i] = a[i] ^ b[i];
        default: ia[i] = ~a[i];
      endcase
    end
  end

  // carry-in cell: depends on opcode only
  assign cin = (op == 3'b001) || (op == 3'b010);

  // shared ripple adder
  assign carry[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_add
    assign res[i]     = ia[i] ^ ib[i] ^ carry[i];
    assign carry[i+1] = (ia[i] & ib[i]) | (carry[i] & (ia[i] ^ ib[i]));
  end
  assign cout = carry[W];

  p_add_r1: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'b000 |-> {cout, res} == {1'b0, a} + {1'b0, b});
  p_sub_r2: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'b001 |-> (res == W'(a - b)) && (cout == (a >= b)));
  p_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'b010 |-> (res == W'(a + 1'b1)) && (cout == (a == '1)));
  p_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'b011 |-> res == a && !cout);
  p_and_r5: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'b100 |-> res == (a & b) && !cout);
  p_or_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'b101 |-> res == (a | b) && !cout);
  p_xor_r7: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'b110 |-> res == (a ^ b) && !cout);
  p_not_r8: assert property (@(posedge clk) disable iff (!rst_n)
    op == 3'b111 |-> res == ~a && !cout);
  p_stateless_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(a) && $stable(b) && $stable(op) |-> $stable(res) && $stable(cout));

endmodule

// File: tb/sim_adder_alu.sv
module sim_adder_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [2:0] op = '0;
  logic [7:0] res;
  logic       cout;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  adder_alu u0 (.clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .res(res), .cout(cout));

  function automatic int ref_val(input int x, input int y, input int o);
    int r;
    case (o)
      0: r = x + y;
      1: r = x + (255 - y) + 1;
      2: r = x + 1;
      3: r = x;
      4: r = x & y;
      5: r = x | y;
      6: r = x ^ y;
      default: r = 255 - x;
    endcase
    return r;
  endfunction

  task automatic apply(input logic [7:0] x, input logic [7:0] y, input logic [2:0] o);
    int exp;
    string rq;
    @(negedge clk);
    a = x; b = y; op = o;
    #1;
    exp = ref_val(int'(x), int'(y), int'(o));
    rq = (o == 0) ? "R1" : (o == 1) ? "R2" : (o == 2) ? "R3" : (o == 3) ? "R4" :
         (o == 4) ? "R5" : (o == 5) ? "R6" : (o == 6) ? "R7" : "R8";
    checks++;
    if ({cout, res} !== 9'(exp)) begin
      errors++;
      $display("FAIL %s op=%0d a=%h b=%h: got %h expected %h", rq, o, x, y, {cout, res}, 9'(exp));
    end
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got hang expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] corners [3] = '{8'h00, 8'hFF, 8'h80};
    logic [8:0] held;
    repeat (2) @(negedge clk);
    // stateless after reset (R9)
    #1; checks++;
    if ({cout, res} !== 9'(ref_val(0, 0, 0))) begin
      errors++; $display("FAIL R9 idle: got %h expected %h", {cout, res}, 9'h000);
    end
    rst_n = 1'b1;
    for (int o = 0; o < 8; o++)
      for (int i = 0; i < 3; i++)
        for (int j = 0; j < 3; j++)
          apply(corners[i], corners[j], 3'(o));
    for (int n = 0; n < 400; n++)
      apply(8'($urandom), 8'($urandom), 3'($urandom));
    // R9: repeated inputs after other traffic give the same output
    apply(8'h5A, 8'hC3, 3'b001);
    held = {cout, res};
    apply(8'hFF, 8'h01, 3'b000);
    apply(8'h5A, 8'hC3, 3'b001);
    checks++;
    if ({cout, res} !== held) begin
      errors++; $display("FAIL R9 repeat: got %h expected %h", {cout, res}, held);
    end
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule